// File: doc/BRIEF.md
# Output-Enable Request Flag Detector

This block watches two active-low emergency request inputs. For each input it keeps a sticky flag that stays set until software clears it. Each input has its own 2-bit mode. The mode picks one of two detectors:

- a falling-edge detector, or
- a low-level detector that samples the pin at one of three divided clock rates and requires a run of low samples.

The OR of the two flags drives a single request output. That output is meant to feed the logic that forces timer outputs into high impedance. That logic is not part of this block.

Software reaches the flags through a single status word. A flag can only be cleared by a protected sequence: read the word and see the flag as 1, then write 0 to that flag. In low-level mode the clear is also refused unless the most recent sample of the pin was high. The register port is plain, with read and write strobes and no handshake. The read data always shows the current status word. Only a cycle with the read strobe high counts as a read for the clear protocol.

Top module: `hiz_req_detect`

## Requirements
- R1: After reset both flags are 0, `hiz_req` is 0 and `reg_rdata` is all zeros.
- R2: The flag for pin 1 is at bit 13 of the status word and the flag for pin 0 is at bit 12. Pin 1 takes its mode from `mode_cfg[3:2]` and pin 0 from `mode_cfg[1:0]`. Mode 00 selects falling-edge detection: a high-to-low change of the synchronized pin sets the flag, and a pin held steadily high or low does not.
- R3: Modes 01, 10 and 11 select low-level detection, sampling the pin at the clock divided by 8, by 16 and by 128 respectively. The flag sets only after 16 consecutive low samples, and any high sample restarts the count.
- R4: Every bit of `reg_rdata` other than 13 and 12 reads 0, including the reserved bits 11:9, whatever has been written.
- R5: Writing 1 to a flag bit never sets it. Writing 0 without a prior read that returned 1 in that flag does not clear it.
- R6: A write with 0 in a flag bit clears that flag if a read with `reg_rd` high has returned it as 1 since the last write. Any write consumes that read marker.
- R7: In a low-level mode the protected clear is refused while the latest sample of the pin is low. It succeeds once a high sample has been taken at the selected rate.
- R8: If a set condition and a valid clear of the same flag fall in the same cycle, the flag stays set.
- R9: `hiz_req` equals the OR of the two flags.
- R10: The two flags are independent: events or modes on one pin never change the other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in_n | input | 2 | Active-low request pins, bit 1 = pin 1 |
| mode_cfg | input | 4 | Detection modes: [3:2] for pin 1, [1:0] for pin 0 |
| reg_rd | input | 1 | Status read strobe |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 16 | Status write data |
| reg_rdata | output | 16 | Status word: flags at 13 and 12, other bits zero |
| hiz_req | output | 1 | Combined high-impedance request |

## Verification
A flag's set and its protected clear can land in the same cycle. To provoke this, the bench arms the read marker on a flag that is already set. It then drives a new falling edge on that pin, timed so that the detection reaches the flag register on exactly the clock edge that samples the clearing write. The flag is judged on the cycle straight after that edge: it must still be 1, whereas a design where the clear wins would show 0 there. A constrained-random phase mixes pulses, reads and writes against a bench model of flags and markers, and directed runs cover the level-mode clear gating and the restart of the low-sample run.

// File: rtl/hrd_pkg.sv
package hrd_pkg;
  typedef enum logic [1:0] {
    DET_FALL      = 2'b00,
    DET_LOW_D8    = 2'b01,
    DET_LOW_D16   = 2'b10,
    DET_LOW_D128  = 2'b11
  } det_mode_e;

  localparam int NUM_PINS  = 2;
  localparam int NUM_TICKS = 3;
endpackage

// File: rtl/hrd_prescaler.sv
module hrd_prescaler #(
  parameter int DIV_A = 8,
  parameter int DIV_B = 16,
  parameter int DIV_C = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] tick
);
  localparam int CNT_W = $clog2(DIV_C);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  // each divisor is a power of two no larger than DIV_C
  for (genvar g = 0; g < 3; g++) begin : g_tick
    localparam int D = (g == 0) ? DIV_A : (g == 1) ? DIV_B : DIV_C;
    localparam logic [CNT_W-1:0] MASK = CNT_W'(D - 1);
    assign tick[g] = ((cnt_q & MASK) == MASK);
  end
endmodule

// File: rtl/hrd_pin_detect.sv
module hrd_pin_detect
  import hrd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_LEN     = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_n,
  input  det_mode_e mode,
  input  logic [2:0] tick,
  output logic      set_req,
  output logic      clr_ok
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;
  logic                   fall;
  logic                   samp;
  logic [RUN_W-1:0]       run_q;
  logic                   hi_seen_q;
  logic                   lvl_set;

  // synchronizer chain, idles high like the pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur  = sync_q[SYNC_STAGES-1];
  assign fall = prev_q & ~cur;

  always_comb begin
    unique case (mode)
      DET_LOW_D8:   samp = tick[0];
      DET_LOW_D16:  samp = tick[1];
      DET_LOW_D128: samp = tick[2];
      default:      samp = 1'b0;
    endcase
  end

  // low-run counter and latest-sample-high marker
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      hi_seen_q <= 1'b0;
    end else if (samp) begin
      if (cur) begin
        run_q     <= '0;
        hi_seen_q <= 1'b1;
      end else begin
        hi_seen_q <= 1'b0;
        if (run_q != RUN_W'(RUN_LEN)) run_q <= run_q + 1'b1;
      end
    end
  end

  assign lvl_set = samp & ~cur & (run_q >= RUN_W'(RUN_LEN - 1));
  assign set_req = (mode == DET_FALL) ? fall : lvl_set;
  assign clr_ok  = (mode == DET_FALL) | hi_seen_q;
endmodule

// File: rtl/hrd_flag_bank.sv
module hrd_flag_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] clr_ok,
  input  logic [N-1:0] wr_bits,
  input  logic         rd,
  input  logic         wr,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] mark_q
);
  logic [N-1:0] clr_hit;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      clr_hit[i] = wr & ~wr_bits[i] & mark_q[i] & clr_ok[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mark_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        // a set condition beats a clear in the same cycle
        if (set_req[i])      flag_q[i] <= 1'b1;
        else if (clr_hit[i]) flag_q[i] <= 1'b0;
        mark_q[i] <= (mark_q[i] & ~wr) | (rd & flag_q[i]);
      end
    end
  end
endmodule

// File: rtl/hiz_req_detect.sv
module hiz_req_detect
  import hrd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int FLAG_LSB    = 12,
  parameter int SYNC_STAGES = 2,
  parameter int RUN_LEN     = 16,
  parameter int DIV_A       = 8,
  parameter int DIV_B       = 16,
  parameter int DIV_C       = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        req_in_n,
  input  logic [3:0]        mode_cfg,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              hiz_req
);
  logic [2:0]          tick;
  logic [NUM_PINS-1:0] set_req;
  logic [NUM_PINS-1:0] clr_ok;
  logic [NUM_PINS-1:0] flag_q;
  logic [NUM_PINS-1:0] mark_q;
  logic [NUM_PINS-1:0] wr_bits;
  logic                unused_wdata;

  assign wr_bits      = reg_wdata[FLAG_LSB +: NUM_PINS];
  assign unused_wdata = ^reg_wdata;

  hrd_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    det_mode_e pin_mode;
    assign pin_mode = det_mode_e'(mode_cfg[2*g +: 2]);

    hrd_pin_detect #(.SYNC_STAGES(SYNC_STAGES), .RUN_LEN(RUN_LEN)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n  (req_in_n[g]),
      .mode   (pin_mode),
      .tick   (tick),
      .set_req(set_req[g]),
      .clr_ok (clr_ok[g])
    );
  end

  hrd_flag_bank #(.N(NUM_PINS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(set_req),
    .clr_ok (clr_ok),
    .wr_bits(wr_bits),
    .rd     (reg_rd),
    .wr     (reg_wr),
    .flag_q (flag_q),
    .mark_q (mark_q)
  );

  always_comb begin
    reg_rdata = '0;
    reg_rdata[FLAG_LSB +: NUM_PINS] = flag_q;
  end

  assign hiz_req = |flag_q;
endmodule

// File: rtl/hrd_checker.sv
module hrd_checker #(
  parameter int DATA_W   = 16,
  parameter int FLAG_LSB = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              hiz_req,
  input logic [1:0]        flag_q,
  input logic [1:0]        mark_q,
  input logic [1:0]        clr_ok
);
  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(3) << FLAG_LSB;

  AST_REQ_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_req == |reg_rdata[FLAG_LSB +: 2]); // R9

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~FLAG_MASK) == '0); // R4

  for (genvar g = 0; g < 2; g++) begin : g_chk
    AST_CLEAR_BY_WRITE0: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[g]) |-> $past(reg_wr && !reg_wdata[FLAG_LSB+g])); // R5

    AST_CLEAR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[g]) |-> $past(mark_q[g])); // R6

    AST_MARK_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reg_wr) && !$past(reg_rd)) |-> !mark_q[g]); // R6

    AST_LEVEL_CLEAR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[g]) |-> $past(clr_ok[g])); // R7
  end
endmodule

bind hiz_req_detect hrd_checker #(.DATA_W(DATA_W), .FLAG_LSB(FLAG_LSB)) u_hrd_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_rd   (reg_rd),
  .reg_wr   (reg_wr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .hiz_req  (hiz_req),
  .flag_q   (flag_q),
  .mark_q   (mark_q),
  .clr_ok   (clr_ok)
);

// File: tb/hiz_req_detect_bench.sv
module hiz_req_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req_in_n = 2'b11;
  logic [3:0]  mode_cfg = 4'b0000;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        hiz_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hiz_req_detect u_hiz_req_detect (
    .clk(clk), .rst_n(rst_n), .req_in_n(req_in_n), .mode_cfg(mode_cfg),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .hiz_req(hiz_req)
  );

  function automatic logic [15:0] exp_word(input logic [1:0] f);
    return {2'b00, f, 12'h000};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] w);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input int p);
    @(negedge clk);
    req_in_n[p] = 1'b0;
    cyc(3);
    req_in_n[p] = 1'b1;
    cyc(5);
  endtask

  logic [15:0] d;
  logic [1:0]  mflag;
  logic [1:0]  mmark;
  logic [15:0] w;

  initial begin
    void'($urandom(32'h1F2E3D4C));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 reset rdata", reg_rdata, 16'h0);
    chk("R1 reset hiz_req", hiz_req, 0);
    cyc(20);
    chk("R2 steady high no set", reg_rdata, 16'h0);

    // R2/R5/R6/R4/R9/R10 constrained random in edge mode
    mflag = 2'b00;
    mmark = 2'b00;
    for (int k = 0; k < 300; k++) begin
      case ($urandom % 3)
        0: begin
          int p = $urandom % 2;
          pulse(p);
          mflag[p] = 1'b1;
          chk("R2 R10 edge set", reg_rdata, exp_word(mflag));
          chk("R9 or of flags", hiz_req, |mflag);
        end
        1: begin
          do_read(d);
          chk("R2 R4 read word", d, exp_word(mflag));
          mmark = mmark | mflag;
        end
        default: begin
          w = 16'($urandom);
          do_write(w);
          for (int i = 0; i < 2; i++)
            if (!w[12+i] && mmark[i]) mflag[i] = 1'b0;
          mmark = 2'b00;
          cyc(1);
          chk("R5 R6 R4 after write", reg_rdata, exp_word(mflag));
        end
      endcase
    end

    // R6 clear both, then R5 write 0 without read does nothing
    do_read(d);
    do_write(16'h0000);
    cyc(1);
    chk("R6 clear both", reg_rdata, 16'h0);
    pulse(0);
    do_write(16'hFFFF);
    do_write(16'h0000);
    cyc(1);
    chk("R5 no clear without read", reg_rdata, exp_word(2'b01));
    do_read(d);
    do_write(16'h0000);
    cyc(1);
    chk("R6 clear after read", reg_rdata, 16'h0);

    // R2 pin held low after edge: clear sticks
    @(negedge clk); req_in_n[1] = 1'b0;
    cyc(6);
    chk("R2 edge held low set", reg_rdata, exp_word(2'b10));
    do_read(d);
    do_write(16'h0000);
    cyc(20);
    chk("R2 steady low no re-set", reg_rdata, 16'h0);
    req_in_n[1] = 1'b1;
    cyc(6);

    // R8 set wins over clear
    pulse(0);
    do_read(d);
    @(negedge clk); req_in_n[0] = 1'b0;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 16'h0000;
    @(negedge clk); reg_wr = 1'b0;
    chk("R8 set wins", reg_rdata, exp_word(2'b01));
    req_in_n[0] = 1'b1;
    cyc(6);
    do_read(d);
    do_write(16'h0000);
    cyc(1);
    chk("R8 cleanup clear", reg_rdata, 16'h0);

    // R3 level /8 on pin 0, with restart
    mode_cfg = 4'b0001;
    @(negedge clk); req_in_n[0] = 1'b0;
    cyc(100);
    chk("R3 d8 partial run", reg_rdata, 16'h0);
    req_in_n[0] = 1'b1;
    cyc(20);
    req_in_n[0] = 1'b0;
    cyc(100);
    chk("R3 d8 restart", reg_rdata, 16'h0);
    cyc(60);
    chk("R3 d8 set", reg_rdata, exp_word(2'b01));
    do_read(d);
    do_write(16'h0000);
    cyc(1);
    chk("R7 clear refused low", reg_rdata, exp_word(2'b01));
    req_in_n[0] = 1'b1;
    cyc(30);
    do_read(d);
    do_write(16'h0000);
    cyc(1);
    chk("R7 clear after high", reg_rdata, 16'h0);

    // R3 level /16 on pin 0
    mode_cfg = 4'b0010;
    @(negedge clk); req_in_n[0] = 1'b0;
    cyc(200);
    chk("R3 d16 not yet", reg_rdata, 16'h0);
    cyc(100);
    chk("R3 d16 set", reg_rdata, exp_word(2'b01));
    req_in_n[0] = 1'b1;
    cyc(40);
    do_read(d);
    do_write(16'h0000);
    cyc(1);
    chk("R7 d16 clear", reg_rdata, 16'h0);

    // R3 level /128 on pin 1, pin 0 untouched (R10)
    mode_cfg = 4'b1100;
    @(negedge clk); req_in_n[1] = 1'b0;
    cyc(1500);
    chk("R3 d128 not yet", reg_rdata, 16'h0);
    cyc(900);
    chk("R3 R10 d128 set pin1 only", reg_rdata, exp_word(2'b10));
    chk("R9 request out", hiz_req, 1);
    req_in_n[1] = 1'b1;
    cyc(300);
    do_read(d);
    do_write(16'h0000);
    cyc(1);
    chk("R7 d128 clear", reg_rdata, 16'h0);
    chk("R9 request idle", hiz_req, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule